// File: doc/BRIEF.md
# Four-Channel Double-Buffered PWM Generator

This block produces one pulse-width-modulated output per channel. Each channel runs from a shared time-base enable, a single-cycle pulse that arrives at 1 MHz. A prescaler in each channel thins that pulse train by 1, 2, 4 or 8. A counter then walks through the period, and the output is active while the count is below the duty value. A polarity bit swaps the active level.

Software programs a channel through a plain register port. There is a write strobe, a byte address and write data, and read data is returned combinationally. Duty and control writes land only in shadow storage. A period write arms a commit. The commit copies all three shadow values into the working set, but only at the end of the period in progress, so a waveform never mixes old and new settings. An idle channel picks up a commit on the next time-base pulse. Committing a zero period lets the running period finish and then parks the output low, whatever the polarity.

Top module: `pwm_shadow_bank`

## Requirements
- R1: After reset every output is low and every register reads back as zero.
- R2: Registers sit at byte addresses 0x400+4·ch (period), 0x420+4·ch (duty) and 0x440+4·ch (control) for ch = 0..3. Reads return the last written (shadow) value, 16 bits for period and duty. Control keeps only bit 5 and bits [1:0], and its other bits read zero. Any other address reads zero.
- R3: Once committed, a channel with period P counts 0..P-1 on prescaled ticks and wraps. Its output is active while the count is below the duty value.
- R4: Control bits [1:0] = n give one prescaled tick per 2^n time-base pulses. The prescaler restarts at every commit, so the count first advances on the 2^n-th pulse after the commit.
- R5: Control bit 5 = 1 inverts the output level of a running channel.
- R6: Duty and control writes that are not followed by a period write never change the output.
- R7: After a period write to a running channel, the new settings take effect exactly at the next period wrap and not before.
- R8: Committing a period of 0 finishes the running period and then holds the output low, including with inverted polarity.
- R9: A period write to an idle channel commits on the next time-base pulse. With no pulse, the output stays low.
- R10: A duty value equal to or above the period gives an output that is active for the whole period. A duty of 0 gives an output that is never active.
- R11: Channels run independently. Programming or running one channel leaves the others' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_tick_i | input | 1 | Single-cycle 1 MHz time-base enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
The main sweep starts each channel from idle with every combination of period 1 to 4, duty 0 to period+1, all four divide settings and both polarities. The bench checks the output after every time-base pulse against a count computed from the pulse index. This separates an off-by-one in the prescaler restart, an error in the duty compare at its boundaries (0, P, above P) and a wrong polarity. In each sweep step a zero period is written in mid-waveform. This shows whether the disable waits for the wrap and whether it forces a low level under inversion. A directed run then keeps two channels going at once and writes duty and control with no period write, then writes the period mid-period. This separates a premature commit from a correctly deferred one, and it also catches crosstalk between channels.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int DIV_SEL_W    = 2;
  localparam int CTRL_INV_POS = 5;

  typedef struct packed {
    logic                 inv;
    logic [DIV_SEL_W-1:0] div;
  } pwm_ctrl_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PERIOD,
    SEL_DUTY,
    SEL_CTRL
  } reg_sel_e;

  function automatic pwm_ctrl_t ctrl_from_word(input logic [7:0] w);
    pwm_ctrl_t c;
    c.inv = w[CTRL_INV_POS];
    c.div = w[DIV_SEL_W-1:0];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_to_word(input pwm_ctrl_t c);
    logic [7:0] w;
    w = '0;
    w[CTRL_INV_POS]    = c.inv;
    w[DIV_SEL_W-1:0]   = c.div;
    return w;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_bank_pkg::*;
#(
  parameter int SEL_W = DIV_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] div_i,
  output logic             ptick_o
);

  localparam int PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] pcnt_q, pcnt_d;
  logic [PS_W-1:0] mask;
  logic            wrap;

  always_comb begin
    mask = PS_W'((1 << div_i) - 1);
    wrap = (pcnt_q == mask);
    ptick_o = tick_i && wrap;
    pcnt_d = pcnt_q;
    if (restart_i) begin
      pcnt_d = '0;
    end else if (tick_i) begin
      pcnt_d = wrap ? '0 : pcnt_q + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

  AST_PS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= mask); // R4

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_period_i,
  input  logic             wr_duty_i,
  input  logic             wr_ctrl_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  pwm_ctrl_t        wctrl_i,
  output logic [CNT_W-1:0] sh_period_o,
  output logic [CNT_W-1:0] sh_duty_o,
  output pwm_ctrl_t        sh_ctrl_o,
  output logic             pwm_o
);

  logic [CNT_W-1:0] sh_per_q, sh_per_d;
  logic [CNT_W-1:0] sh_dut_q, sh_dut_d;
  pwm_ctrl_t        sh_ctl_q, sh_ctl_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] act_per_q, act_per_d;
  logic [CNT_W-1:0] act_dut_q, act_dut_d;
  pwm_ctrl_t        act_ctl_q, act_ctl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic run, ptick, last, commit;

  pwm_prescaler #(.SEL_W(DIV_SEL_W)) i_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .restart_i (commit),
    .div_i     (act_ctl_q.div),
    .ptick_o   (ptick)
  );

  always_comb begin
    run    = (act_per_q != '0);
    last   = run && ptick && (cnt_q == act_per_q - CNT_W'(1));
    commit = pend_q && (run ? last : tick_i);

    sh_per_d = wr_period_i ? wdata_i : sh_per_q;
    sh_dut_d = wr_duty_i   ? wdata_i : sh_dut_q;
    sh_ctl_d = wr_ctrl_i   ? wctrl_i : sh_ctl_q;

    pend_d = pend_q;
    if (wr_period_i) begin
      pend_d = 1'b1;
    end else if (commit) begin
      pend_d = 1'b0;
    end

    act_per_d = act_per_q;
    act_dut_d = act_dut_q;
    act_ctl_d = act_ctl_q;
    cnt_d     = cnt_q;
    if (commit) begin
      act_per_d = sh_per_q;
      act_dut_d = sh_dut_q;
      act_ctl_d = sh_ctl_q;
      cnt_d     = '0;
    end else if (run && ptick) begin
      cnt_d = last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_per_q  <= '0;
      sh_dut_q  <= '0;
      sh_ctl_q  <= '0;
      pend_q    <= 1'b0;
      act_per_q <= '0;
      act_dut_q <= '0;
      act_ctl_q <= '0;
      cnt_q     <= '0;
    end else begin
      sh_per_q  <= sh_per_d;
      sh_dut_q  <= sh_dut_d;
      sh_ctl_q  <= sh_ctl_d;
      pend_q    <= pend_d;
      act_per_q <= act_per_d;
      act_dut_q <= act_dut_d;
      act_ctl_q <= act_ctl_d;
      cnt_q     <= cnt_d;
    end
  end

  assign sh_period_o = sh_per_q;
  assign sh_duty_o   = sh_dut_q;
  assign sh_ctrl_o   = sh_ctl_q;
  assign pwm_o       = run && ((cnt_q < act_dut_q) ^ act_ctl_q.inv);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_per_q != '0) |-> (cnt_q < act_per_q)); // R3

  AST_HOLD_WORKING_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_per_q) && $stable(act_dut_q) && $stable(act_ctl_q))); // R6

  AST_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$stable(act_dut_q)) |->
      ($past(ptick) && ($past(cnt_q) == CNT_W'($past(act_per_q) - 1'b1)))); // R7

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pend_q) |=> !run); // R8

  AST_IDLE_PARKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> !pwm_o); // R8

endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_bank_pkg::*;
#(
  parameter int              NCH      = 4,
  parameter int              CNT_W    = 16,
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 32,
  parameter logic [11:0]     PER_BASE = 12'h400,
  parameter logic [11:0]     DUT_BASE = 12'h420,
  parameter logic [11:0]     CTL_BASE = 12'h440
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NCH-1:0]    pwm_o
);

  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int GRP_LO = 5;

  logic       rst_meta_q, rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n_int = rst_sync_q;

  logic [2:0]                 slot;
  logic [ADDR_W-GRP_LO-1:0]   grp;
  logic [CH_W-1:0]            chan;
  logic                       slot_ok;
  reg_sel_e                   sel;
  pwm_ctrl_t                  wctrl;
  logic [DATA_W-CNT_W-1:0]    unused_wdata_hi;

  always_comb begin
    grp     = bus_addr_i[ADDR_W-1:GRP_LO];
    slot    = bus_addr_i[4:2];
    chan    = slot[CH_W-1:0];
    slot_ok = (bus_addr_i[1:0] == 2'b00) && (int'(slot) < NCH);
    sel     = SEL_NONE;
    if (slot_ok) begin
      if (grp == PER_BASE[ADDR_W-1:GRP_LO]) begin
        sel = SEL_PERIOD;
      end else if (grp == DUT_BASE[ADDR_W-1:GRP_LO]) begin
        sel = SEL_DUTY;
      end else if (grp == CTL_BASE[ADDR_W-1:GRP_LO]) begin
        sel = SEL_CTRL;
      end
    end
    wctrl = ctrl_from_word(bus_wdata_i[7:0]);
  end

  assign unused_wdata_hi = bus_wdata_i[DATA_W-1:CNT_W];

  logic [CNT_W-1:0] sh_per [NCH];
  logic [CNT_W-1:0] sh_dut [NCH];
  pwm_ctrl_t        sh_ctl [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = bus_wr_i && (chan == CH_W'(g));

    pwm_channel #(.CNT_W(CNT_W)) i_ch (
      .clk         (clk),
      .rst_n       (rst_n_int),
      .tick_i      (base_tick_i),
      .wr_period_i (hit && (sel == SEL_PERIOD)),
      .wr_duty_i   (hit && (sel == SEL_DUTY)),
      .wr_ctrl_i   (hit && (sel == SEL_CTRL)),
      .wdata_i     (bus_wdata_i[CNT_W-1:0]),
      .wctrl_i     (wctrl),
      .sh_period_o (sh_per[g]),
      .sh_duty_o   (sh_dut[g]),
      .sh_ctrl_o   (sh_ctl[g]),
      .pwm_o       (pwm_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (sel)
      SEL_PERIOD: bus_rdata_o[CNT_W-1:0] = sh_per[chan];
      SEL_DUTY:   bus_rdata_o[CNT_W-1:0] = sh_dut[chan];
      SEL_CTRL:   bus_rdata_o[7:0]       = ctrl_to_word(sh_ctl[chan]);
      default:    bus_rdata_o            = '0;
    endcase
  end

  AST_RESET_OUT_LOW: assert property (@(posedge clk)
    !rst_n_int |-> (pwm_o == '0)); // R1

endmodule

// File: tb/test_pwm_shadow_bank.sv
module test_pwm_shadow_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_tick;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwm_shadow_bank i_pwm_shadow_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_tick_i (base_tick),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .pwm_o       (pwm)
  );

  function automatic logic [11:0] a_per(input int ch); return 12'(12'h400 + 4 * ch); endfunction
  function automatic logic [11:0] a_dut(input int ch); return 12'(12'h420 + 4 * ch); endfunction
  function automatic logic [11:0] a_ctl(input int ch); return 12'(12'h440 + 4 * ch); endfunction

  function automatic logic wave(input int j, input int p, input int d, input int dv, input bit inv);
    int t;
    t = (j >> dv) % p;
    return (t < d) ^ inv;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse();
    @(negedge clk);
    base_tick = 1'b1;
    @(negedge clk);
    base_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; base_tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    chk("R1 out in reset", {28'b0, pwm}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 out after reset", {28'b0, pwm}, 32'h0);
    for (int ch = 0; ch < 4; ch++) begin
      rd_chk("R1 period", a_per(ch), 32'h0);
      rd_chk("R1 duty", a_dut(ch), 32'h0);
      rd_chk("R1 ctrl", a_ctl(ch), 32'h0);
    end

    // R2: control keeps bit 5 and bits [1:0]; unmapped reads zero
    wr(a_ctl(2), 32'hFFFF_FFFF);
    rd_chk("R2 ctrl mask", a_ctl(2), 32'h23);
    wr(a_dut(2), 32'h1234_ABCD);
    rd_chk("R2 duty 16b", a_dut(2), 32'hABCD);
    rd_chk("R2 unmapped slot", 12'h410, 32'h0);
    rd_chk("R2 unaligned", 12'h401, 32'h0);
    pulse(); pulse();
    chk("R6 no period write", {28'b0, pwm}, 32'h0);
    wr(a_ctl(2), 32'h0);
    wr(a_dut(2), 32'h0);

    // Sweep: R3 R4 R5 R8 R9 R10 R11
    for (int ch = 0; ch < 4; ch++)
      for (int dv = 0; dv < 4; dv++)
        for (int inv = 0; inv < 2; inv++)
          for (int p = 1; p <= 4; p++)
            for (int d = 0; d <= p + 1; d++) begin
              int dd;
              int pd;
              dd = 1 << dv;
              pd = p * dd;
              wr(a_ctl(ch), 32'(inv * 32 + dv));
              wr(a_dut(ch), 32'(d));
              wr(a_per(ch), 32'(p));
              rd_chk("R2 ctrl rb", a_ctl(ch), 32'(inv * 32 + dv));
              rd_chk("R2 duty rb", a_dut(ch), 32'(d));
              rd_chk("R2 period rb", a_per(ch), 32'(p));
              chk("R9 idle before pulse", {28'b0, pwm}, 32'h0);
              for (int j = 0; j < 3 * pd + 2; j++) begin
                logic e;
                pulse();
                if (j < 2 * pd) begin
                  e = wave(j, p, d, dv, inv[0]);
                  chk("R3/R4/R5/R10/R11 wave", {28'b0, pwm}, 32'(e) << ch);
                end else begin
                  chk("R8 parked low", {28'b0, pwm}, 32'h0);
                end
                if (j == pd) wr(a_per(ch), 32'h0);
              end
            end

    // Directed: R6 R7 R9 R11 with two channels running
    wr(a_ctl(3), 32'h0); wr(a_dut(3), 32'd1); wr(a_per(3), 32'd2);
    wr(a_ctl(1), 32'h0); wr(a_dut(1), 32'd1); wr(a_per(1), 32'd4);
    chk("R9 no pulse yet", {28'b0, pwm}, 32'h0);
    for (int j = 0; j < 22; j++) begin
      logic e1, e3;
      pulse();
      e3 = wave(j, 2, 1, 0, 1'b0);
      if (j < 12) e1 = wave(j, 4, 1, 0, 1'b0);
      else        e1 = wave(j - 12, 5, 3, 0, 1'b1);
      chk("R6/R7/R11 directed", {28'b0, pwm}, (32'(e3) << 3) | (32'(e1) << 1));
      if (j == 1) begin
        wr(a_dut(1), 32'd3);
        wr(a_ctl(1), 32'h20);
      end
      if (j == 9) wr(a_per(1), 32'd5);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule